// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is a 12-pin general-purpose I/O port attached to a simple memory-mapped register bus. Its main feature is a 16 KB data window in which the word address itself carries a per-pin mask. Address bits 13:2 of any data access choose which pins the access touches. Software can therefore raise or lower any subset of pins in a single bus write, without first reading the port.

A per-pin direction register sets which pins are outputs. The block drives the output levels and output enables for the pads. It samples the pad inputs through a two-stage synchronizer. A read of the data window returns the present level of each pin that is selected by the mask. That level is the driven value for an output pin and the synchronized pad level for an input pin.

The bus uses a request strobe with a write flag, a byte address and write data. Every request receives a response strobe and read data exactly one cycle later.

Top module: `mgpio_port`

## Requirements
- R1: After reset `pin_out` is 0, `pin_oe` is 0 (every pin is an input) and `rsp_valid` is 0.
- R2: A write whose address lies in the data window (`req_addr[15:14]==0`, `req_addr[1:0]==0`) sets pin n of the output latch to `req_wdata[n]` only when `req_addr[n+2]` is 1. Every other pin keeps its value, whatever its write data bit is.
- R3: A data write at offset 0x3FFC loads all 12 pins from `req_wdata[11:0]`. A data write at offset 0x0000 changes no pin.
- R4: A write at offset 0x1024 with write data 0x409 or 0xFFF drives pins 0, 3 and 10 high and leaves the other nine pins unchanged.
- R5: The direction register is at offset 0x8000, and bit n = 1 makes pin n an output. `pin_oe` equals the direction register from the cycle after the write. A read of 0x8000 returns the register in bits 11:0.
- R6: A data-window read returns, for each pin whose mask bit is 1, the latch value if the pin is an output. For an input pin it returns `pin_in` as sampled two clock edges earlier.
- R7: In a data-window read, bits whose mask bit is 0 read as 0. Bits 31:12 of every response are 0.
- R8: Any other offset, including offsets whose bits 1:0 are not zero, is unmapped. A write there changes neither `pin_out` nor `pin_oe`, and a read there returns 0.
- R9: Each request accepted at a clock edge (`req_valid` high) produces `rsp_valid` high for exactly the following cycle, and `rsp_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset of the access |
| req_wdata | input | 32 | Write data; bits 11:0 used |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; 0 for writes and unmapped reads |
| pin_in | input | 12 | Pad input levels, asynchronous |
| pin_out | output | 12 | Output latch driven to the pads |
| pin_oe | output | 12 | Per-pin output enable |

## Verification
A corrupted output latch or direction bit appears on `pin_out` or `pin_oe` in the cycle right after the write that caused it. It is also returned by the next full-mask read. A mask decoded from the wrong address bits shows up as a wrong pin being changed, or a wrong bit being returned, on the first masked access that touches that pin. A synchronizer with the wrong depth shows up when an input pin is read two edges after its pad level changes.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    localparam int NPIN     = 12;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 32;
    localparam int SYNC_LEN = 2;

    localparam int MASK_LO  = 2;
    localparam int WIN_TOP  = NPIN + MASK_LO;
    localparam logic [ADDR_W-1:0] DIR_OFS = 16'h8000;

    typedef enum logic [1:0] {
        RG_DATA = 2'd0,
        RG_DIR  = 2'd1,
        RG_NONE = 2'd2
    } region_e;

    typedef struct packed {
        region_e          region;
        logic [NPIN-1:0]  mask;
    } decode_t;

    function automatic logic [NPIN-1:0] merge_bits(
        input logic [NPIN-1:0] old_v,
        input logic [NPIN-1:0] new_v,
        input logic [NPIN-1:0] sel
    );
        return (old_v & ~sel) | (new_v & sel);
    endfunction

endpackage

// File: rtl/mgpio_decode.sv
module mgpio_decode
    import mgpio_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output decode_t           dec
);
    logic in_window;
    logic aligned;

    always_comb begin
        aligned   = (addr[MASK_LO-1:0] == '0);
        in_window = aligned && (addr[ADDR_W-1:WIN_TOP] == '0);
        dec.mask  = addr[WIN_TOP-1:MASK_LO];
        if (in_window)
            dec.region = RG_DATA;
        else if (addr == DIR_OFS)
            dec.region = RG_DIR;
        else
            dec.region = RG_NONE;
    end
endmodule

// File: rtl/mgpio_sync.sv
module mgpio_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[s] <= '0;
                else if (s == 0)
                    chain[s] <= d;
                else
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
    import mgpio_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  decode_t         dec,
    input  logic [NPIN-1:0] wbits,
    output logic [NPIN-1:0] out_q,
    output logic [NPIN-1:0] dir_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
        end else if (wr_en) begin
            case (dec.region)
                RG_DATA: out_q <= merge_bits(out_q, wbits, dec.mask);
                RG_DIR:  dir_q <= wbits;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mgpio_port.sv
module mgpio_port
    import mgpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);
    decode_t          dec;
    logic [NPIN-1:0]  in_sync;
    logic [NPIN-1:0]  out_q;
    logic [NPIN-1:0]  dir_q;
    logic [NPIN-1:0]  level;
    logic [NPIN-1:0]  rd_bits;
    logic             unused_hi;

    assign unused_hi = ^req_wdata[DATA_W-1:NPIN];

    mgpio_decode u_dec (
        .addr (req_addr),
        .dec  (dec)
    );

    mgpio_sync #(.W(NPIN), .STAGES(SYNC_LEN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    mgpio_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (req_valid && req_write),
        .dec   (dec),
        .wbits (req_wdata[NPIN-1:0]),
        .out_q (out_q),
        .dir_q (dir_q)
    );

    always_comb begin
        level = merge_bits(in_sync, out_q, dir_q);
        case (dec.region)
            RG_DATA: rd_bits = level & dec.mask;
            RG_DIR:  rd_bits = dir_q;
            default: rd_bits = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= '0;
            if (req_valid && !req_write)
                rsp_rdata[NPIN-1:0] <= rd_bits;
        end
    end

    assign pin_out = out_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk
    import mgpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic [NPIN-1:0]   pin_out,
    input logic [NPIN-1:0]   pin_oe
);
    logic data_acc;
    logic dir_acc;
    logic [NPIN-1:0] amask;

    assign data_acc = (req_addr[15:14] == 2'b00) && (req_addr[1:0] == 2'b00);
    assign dir_acc  = (req_addr == 16'h8000);
    assign amask    = req_addr[13:2];

    AST_MASKED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && data_acc) |=>
        (pin_out == (($past(pin_out) & ~$past(amask)) | ($past(req_wdata[NPIN-1:0]) & $past(amask)))))
        else $error("masked write mismatch"); // R2

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && dir_acc) |=> (pin_oe == $past(req_wdata[NPIN-1:0])))
        else $error("direction not applied"); // R5

    AST_READ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && data_acc) |=> ((rsp_rdata[NPIN-1:0] & ~$past(amask)) == '0))
        else $error("masked-off bit returned"); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[DATA_W-1:NPIN] == '0))
        else $error("upper bits nonzero"); // R7

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !data_acc && !dir_acc) |=> ($stable(pin_out) && $stable(pin_oe) && rsp_rdata == '0))
        else $error("unmapped access had effect"); // R8

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid)
        else $error("missing response"); // R9

    AST_RSP_NOREQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid)
        else $error("spurious response"); // R9
endmodule

bind mgpio_port mgpio_port_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_mgpio_port.sv
module test_mgpio_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out;
    logic [11:0] pin_oe;

    int checks = 0;
    int errors = 0;
    logic [11:0] m_out = '0;
    logic [11:0] m_dir = '0;
    logic [31:0] rd;
    bit          done = 0;

    always #10 clk = ~clk;

    mgpio_port i_mgpio_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic bit is_data(input logic [15:0] a);
        return (a[15:14] == 2'b00) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        logic [11:0] lvl;
        lvl = (m_out & m_dir) | (pin_in & ~m_dir);
        if (is_data(a)) return {20'd0, lvl & a[13:2]};
        if (a == 16'h8000) return {20'd0, m_dir};
        return 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one access; the response is sampled at the next falling edge
    task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] d,
                          input string req);
        logic [31:0] e;
        e = wr ? 32'd0 : exp_read(a);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (wr) begin
            if (is_data(a)) m_out = (m_out & ~a[13:2]) | (d[11:0] & a[13:2]);
            else if (a == 16'h8000) m_dir = d[11:0];
        end
        check("R9", {31'd0, rsp_valid}, 32'd1);
        check(req, rsp_rdata, e);
        check(req, {20'd0, pin_out}, {20'd0, m_out});
        check(req, {20'd0, pin_oe}, {20'd0, m_dir});
        rd = rsp_rdata;
        @(negedge clk);
        check("R9", {31'd0, rsp_valid}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        idle(3);
        check("R1", {31'd0, rsp_valid}, 32'd0);
        check("R1", {20'd0, pin_out}, 32'd0);
        check("R1", {20'd0, pin_oe}, 32'd0);
        rst = 1'b0;
        idle(1);
        check("R1", {20'd0, pin_out, 12'd0}, 32'd0);

        // directed corners
        access(1, 16'h3FFC, 32'hFFFF_F555, "R3");
        access(1, 16'h0000, 32'h0000_0AAA, "R3");
        access(1, 16'h3FFC, 32'h0000_0000, "R3");
        access(1, 16'h1024, 32'h0000_0409, "R4");
        check("R4", {20'd0, pin_out}, 32'h0000_0409);
        access(1, 16'h3FFC, 32'h0000_0202, "R4");
        access(1, 16'h1024, 32'h0000_0FFF, "R4");
        check("R4", {20'd0, pin_out}, 32'h0000_060B);
        access(1, 16'h8000, 32'hFFFF_0F0F, "R5");
        access(0, 16'h8000, 32'h0, "R5");
        pin_in = 12'hA5C;
        idle(2);
        access(0, 16'h3FFC, 32'h0, "R6");
        access(0, 16'h0930, 32'h0, "R7");
        access(1, 16'h3FFE, 32'h0000_0000, "R8");
        access(0, 16'h3FFE, 32'h0, "R8");
        access(1, 16'h8004, 32'h0000_0000, "R8");
        access(1, 16'h4000, 32'h0000_0000, "R8");
        access(0, 16'h7FFC, 32'h0, "R8");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            int kind;
            logic [15:0] a;
            logic [31:0] d;
            kind = $urandom_range(0, 9);
            d    = $urandom();
            case (kind)
                0, 1, 2: a = {2'b00, 12'($urandom()), 2'b00};
                3:       a = 16'h8000;
                4:       a = 16'($urandom_range(16'h4000, 16'hFFFF));
                default: a = {2'b00, 12'($urandom()), 2'b00};
            endcase
            if (kind == 9) begin
                pin_in = 12'($urandom());
                idle(2);
            end
            if (kind <= 4) access(1, a, d, (kind == 3) ? "R5" : (kind == 4 ? "R8" : "R2"));
            else           access(0, a, 32'h0, (kind == 9) ? "R6" : "R7");
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule